// File: doc/BRIEF.md
# Graphics Interrupt Control Register

This block collects interrupt events from a display and graphics subsystem and drives one interrupt line to the host. There are five event sources: a 2D block-transfer engine going idle, that engine's command queue dropping below its low watermark, the end of the active display area on display pipeline A and on pipeline B, and the start of a vertical sync pulse from a video capture input. The event generators are outside the block. Each one arrives as a level input, and the block turns every rising edge of that level into a single-cycle trigger.

Four sources have only an enable bit. When the bit is set, a trigger from that source pulses the host interrupt for one cycle. The queue-low source has no enable bit. It sets a sticky pending flag that software clears by writing a one to it. The host interrupt stays high for as long as that flag is set. The register answers at two memory offsets, and both offsets reach the same storage. A write takes effect only when all four byte enables are set. A read can return a byte, a 16-bit word or the whole 32-bit word.

Top module: `gint_ctrl`

## Requirements
- R1: After reset, every implemented bit is 0, `host_irq` is 0, and a full read of the register returns 0x00000000.
- R2: The register decodes at offsets 0x400600 and 0xC00600, and both reach the same storage. A write to any other offset changes nothing. A read of any other offset returns 0.
- R3: A write is accepted only when `reg_be` is 4'b1111. A write with any other byte-enable pattern leaves the register unchanged.
- R4: Bits 31 (block-transfer idle enable), 18 (pipeline B end-of-active enable), 14 (pipeline A end-of-active enable) and 6 (capture vsync enable) can be written and read back. Every other bit except bit 30 always reads 0, even after a write of all ones.
- R5: Read data is combinational in the cycle that `reg_rd` is high. Byte lane n (bits 8n+7..8n) carries register data only when `reg_be[n]` is set, and reads 0 otherwise. `reg_rdata` is 0 whenever no decoded read is in progress.
- R6: When bit 31 is set, a rising edge on `evt_blit_idle` drives `host_irq` high for exactly one cycle: the cycle after the clock edge that first samples the input high. Holding the input high gives no further pulse.
- R7: Bits 14, 18 and 6 gate rising edges of `evt_pipe_a_end`, `evt_pipe_b_end` and `evt_cap_vsync` in the same way, each giving a one-cycle pulse with the same latency as R6.
- R8: A rising edge from a source whose enable bit is 0 does not raise `host_irq`.
- R9: A rising edge on `evt_queue_low` sets bit 30, whatever the enable bits hold. From the next cycle, `host_irq` stays high for as long as bit 30 is set.
- R10: An accepted write with bit 30 = 1 clears bit 30, and `host_irq` falls in the next cycle. An accepted write with bit 30 = 0 leaves bit 30 unchanged.
- R11: If a queue-low rising edge and a clearing write fall on the same clock edge, bit 30 ends up as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 24 | Byte offset of the access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe |
| reg_be | input | 4 | Byte enables for the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, masked per lane |
| evt_blit_idle | input | 1 | Block-transfer engine idle level |
| evt_queue_low | input | 1 | Command queue below low watermark level |
| evt_pipe_a_end | input | 1 | Pipeline A end-of-active-area level |
| evt_pipe_b_end | input | 1 | Pipeline B end-of-active-area level |
| evt_cap_vsync | input | 1 | Capture vertical sync level |
| host_irq | output | 1 | Interrupt line to the host |

## Verification
Read data is due in the same cycle as the read strobe, so the bench samples it 2 ns after the edge while the strobe is still held. An event input sampled high at edge k is due on `host_irq` right after edge k, and the bench checks it there. An enabled pulse must be gone after edge k+1. A write at edge k has its effect visible after that same edge, both in the stored bits and in a falling `host_irq`. The bench's behavioural model takes in the same sampled inputs at every edge and is compared against both outputs 2 ns later.

// File: rtl/gint_pkg.sv
package gint_pkg;
  localparam int DATA_W   = 32;
  localparam int BIT_IDLE = 31;
  localparam int BIT_QLOW = 30;
  localparam int BIT_PB   = 18;
  localparam int BIT_PA   = 14;
  localparam int BIT_VCAP = 6;

  localparam int NSRC     = 5;
  localparam int SRC_IDLE = 0;
  localparam int SRC_QLOW = 1;
  localparam int SRC_PA   = 2;
  localparam int SRC_PB   = 3;
  localparam int SRC_VCAP = 4;

  typedef struct packed {
    logic idle;
    logic pipe_b;
    logic pipe_a;
    logic vcap;
  } gint_en_t;
endpackage

// File: rtl/gint_edge.sv
module gint_edge #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] trig
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= lvl[i];
    end
    assign trig[i] = lvl[i] & ~prev_q[i];
  end
endmodule

// File: rtl/gint_regs.sv
module gint_regs
  import gint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSRC-1:0]   trig,
  output gint_en_t          en_q,
  output logic              pend_q,
  output logic              irq_q,
  output logic [DATA_W-1:0] word
);
  logic pend_d;
  logic hit;

  always_comb begin
    pend_d = pend_q;
    if (wr_ok && wdata[BIT_QLOW]) pend_d = 1'b0;
    if (trig[SRC_QLOW])           pend_d = 1'b1;
  end

  assign hit = (trig[SRC_IDLE] & en_q.idle)   |
               (trig[SRC_PB]   & en_q.pipe_b) |
               (trig[SRC_PA]   & en_q.pipe_a) |
               (trig[SRC_VCAP] & en_q.vcap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= pend_d | hit;
      if (wr_ok) begin
        en_q.idle   <= wdata[BIT_IDLE];
        en_q.pipe_b <= wdata[BIT_PB];
        en_q.pipe_a <= wdata[BIT_PA];
        en_q.vcap   <= wdata[BIT_VCAP];
      end
    end
  end

  always_comb begin
    word           = '0;
    word[BIT_IDLE] = en_q.idle;
    word[BIT_QLOW] = pend_q;
    word[BIT_PB]   = en_q.pipe_b;
    word[BIT_PA]   = en_q.pipe_a;
    word[BIT_VCAP] = en_q.vcap;
  end
endmodule

// File: rtl/gint_rdmux.sv
module gint_rdmux #(
  parameter int DW = 32,
  localparam int LANES = DW / 8
) (
  input  logic             rd_en,
  input  logic [LANES-1:0] be,
  input  logic [DW-1:0]    word,
  output logic [DW-1:0]    rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rdata[8*l +: 8] = (rd_en && be[l]) ? word[8*l +: 8] : 8'h00;
  end
endmodule

// File: rtl/gint_ctrl.sv
module gint_ctrl
  import gint_pkg::*;
#(
  parameter int          ADDR_W = 24,
  parameter logic [23:0] OFS_LO = 24'h400600,
  parameter logic [23:0] OFS_HI = 24'hC00600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              evt_blit_idle,
  input  logic              evt_queue_low,
  input  logic              evt_pipe_a_end,
  input  logic              evt_pipe_b_end,
  input  logic              evt_cap_vsync,
  output logic              host_irq
);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(OFS_LO);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(OFS_HI);

  logic            sel;
  logic            wr_ok;
  logic            rd_en;
  logic [NSRC-1:0] lvl;
  logic [NSRC-1:0] trig;
  gint_en_t        en_q;
  logic            pend_q;
  logic [31:0]     word;

  assign sel   = (reg_addr == A_LO) || (reg_addr == A_HI);
  assign wr_ok = reg_wr && sel && (&reg_be);
  assign rd_en = reg_rd && sel;

  always_comb begin
    lvl           = '0;
    lvl[SRC_IDLE] = evt_blit_idle;
    lvl[SRC_QLOW] = evt_queue_low;
    lvl[SRC_PA]   = evt_pipe_a_end;
    lvl[SRC_PB]   = evt_pipe_b_end;
    lvl[SRC_VCAP] = evt_cap_vsync;
  end

  gint_edge #(.N(NSRC)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (lvl),
    .trig (trig)
  );

  gint_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_ok (wr_ok),
    .wdata (reg_wdata),
    .trig  (trig),
    .en_q  (en_q),
    .pend_q(pend_q),
    .irq_q (host_irq),
    .word  (word)
  );

  gint_rdmux #(.DW(32)) u_rdmux (
    .rd_en(rd_en),
    .be   (reg_be),
    .word (word),
    .rdata(reg_rdata)
  );
endmodule

// File: rtl/gint_ctrl_chk.sv
module gint_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [3:0]  reg_be,
  input logic [31:0] reg_rdata,
  input logic        evt_blit_idle,
  input logic        evt_queue_low,
  input logic        evt_pipe_a_end,
  input logic        host_irq,
  input logic [3:0]  en_bits,
  input logic        pend
);
  localparam logic [31:0] IMPL = 32'hC004_4040;

  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~IMPL) == 32'h0);
  a_r5_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> reg_rdata == 32'h0);
  a_r3_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_be != 4'hF) |=> $stable(en_bits));
  a_r6_idle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (en_bits[3] && $rose(evt_blit_idle)) |=> host_irq);
  a_r7_pipe_a_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (en_bits[1] && $rose(evt_pipe_a_end)) |=> host_irq);
  a_r9_pend_drives_irq: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> host_irq);
  a_r10_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !reg_wr) |=> pend);
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_queue_low) |=> pend);
endmodule

bind gint_ctrl gint_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr        (reg_wr),
  .reg_rd        (reg_rd),
  .reg_be        (reg_be),
  .reg_rdata     (reg_rdata),
  .evt_blit_idle (evt_blit_idle),
  .evt_queue_low (evt_queue_low),
  .evt_pipe_a_end(evt_pipe_a_end),
  .host_irq      (host_irq),
  .en_bits       (en_q),
  .pend          (pend_q)
);

// File: tb/test_gint_ctrl.sv
module test_gint_ctrl;
  localparam logic [23:0] ADR_A = 24'h400600;
  localparam logic [23:0] ADR_B = 24'hC00600;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        idle = 0, qlow = 0, pa = 0, pb = 0, vcap = 0;
  logic        host_irq;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gint_ctrl i_gint_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .evt_blit_idle(idle), .evt_queue_low(qlow),
    .evt_pipe_a_end(pa), .evt_pipe_b_end(pb), .evt_cap_vsync(vcap),
    .host_irq(host_irq)
  );

  // behavioural reference model
  bit m_idle_en, m_pb_en, m_pa_en, m_vc_en, m_pend, m_irq;
  bit p_idle, p_qlow, p_pa, p_pb, p_vcap;

  function automatic logic [31:0] exp_rdata();
    logic [31:0] w;
    w = 0;
    w[31] = m_idle_en; w[30] = m_pend; w[18] = m_pb_en;
    w[14] = m_pa_en;   w[6]  = m_vc_en;
    if (!reg_rd || (reg_addr != ADR_A && reg_addr != ADR_B)) return 32'h0;
    for (int l = 0; l < 4; l++)
      if (!reg_be[l]) w[8*l +: 8] = 8'h00;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_idle_en, m_pb_en, m_pa_en, m_vc_en, m_pend, m_irq} = '0;
      {p_idle, p_qlow, p_pa, p_pb, p_vcap} = '0;
    end else begin
      bit wok, ti, tq, ta, tb, tv;
      wok = reg_wr && (reg_addr == ADR_A || reg_addr == ADR_B) && reg_be == 4'hF;
      ti = idle && !p_idle; tq = qlow && !p_qlow; ta = pa && !p_pa;
      tb = pb && !p_pb;     tv = vcap && !p_vcap;
      if (wok && reg_wdata[30]) m_pend = 0;
      if (tq) m_pend = 1;
      m_irq = m_pend | (ti & m_idle_en) | (tb & m_pb_en) | (ta & m_pa_en) | (tv & m_vc_en);
      if (wok) begin
        m_idle_en = reg_wdata[31]; m_pb_en = reg_wdata[18];
        m_pa_en = reg_wdata[14];   m_vc_en = reg_wdata[6];
      end
      {p_idle, p_qlow, p_pa, p_pb, p_vcap} = {idle, qlow, pa, pb, vcap};
      #2;
      chk(m_pend ? "R9 model irq" : "R6 model irq", {31'b0, host_irq}, {31'b0, m_irq});
      chk("R5 model rdata", reg_rdata, exp_rdata());
    end
  end

  task automatic wr(input logic [23:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_be = be; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0; reg_be = 0;
  endtask

  task automatic rd(input logic [23:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_be = be; reg_rd = 1;
    @(posedge clk); #2;
    d = reg_rdata;
    @(negedge clk);
    reg_rd = 0; reg_be = 0;
  endtask

  task automatic irq_at(input string tag, input logic exp);
    @(posedge clk); #2;
    chk(tag, {31'b0, host_irq}, {31'b0, exp});
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    #1 chk("R1 irq during reset", {31'b0, host_irq}, 32'h0);
    rst_n = 1;
    rd(ADR_A, 4'hF, d);  chk("R1 reset value", d, 32'h0);

    wr(ADR_A, 4'hF, 32'hFFFF_FFFF);
    rd(ADR_A, 4'hF, d);  chk("R4 writable bits", d, 32'h8004_4040);
    rd(ADR_B, 4'hF, d);  chk("R2 alias offset", d, 32'h8004_4040);
    rd(ADR_A, 4'b0001, d); chk("R5 lane0", d, 32'h0000_0040);
    rd(ADR_B, 4'b0010, d); chk("R5 lane1", d, 32'h0000_4000);
    rd(ADR_A, 4'b0100, d); chk("R5 lane2", d, 32'h0004_0000);
    rd(ADR_A, 4'b1000, d); chk("R5 lane3", d, 32'h8000_0000);
    rd(ADR_A, 4'b1100, d); chk("R5 upper word", d, 32'h8004_0000);
    rd(24'h400604, 4'hF, d); chk("R2 other offset read", d, 32'h0);
    wr(24'h400700, 4'hF, 32'h0);
    rd(ADR_A, 4'hF, d);  chk("R2 other offset write", d, 32'h8004_4040);
    wr(ADR_B, 4'b0111, 32'h0);
    rd(ADR_A, 4'hF, d);  chk("R3 partial write", d, 32'h8004_4040);
    wr(ADR_B, 4'hF, 32'h0000_4000);
    rd(ADR_A, 4'hF, d);  chk("R2 write via alias", d, 32'h0000_4000);
    wr(ADR_A, 4'hF, 32'h8004_4040);

    @(negedge clk) idle = 1;
    irq_at("R6 idle pulse", 1); irq_at("R6 pulse ends", 0); irq_at("R6 held level", 0);
    @(negedge clk) idle = 0;
    @(negedge clk) pa = 1;
    irq_at("R7 pipe A pulse", 1); irq_at("R7 pipe A ends", 0);
    @(negedge clk) begin pa = 0; pb = 1; end
    irq_at("R7 pipe B pulse", 1); irq_at("R7 pipe B ends", 0);
    @(negedge clk) begin pb = 0; vcap = 1; end
    irq_at("R7 vsync pulse", 1); irq_at("R7 vsync ends", 0);
    @(negedge clk) vcap = 0;

    wr(ADR_A, 4'hF, 32'h0);
    @(negedge clk) begin idle = 1; pa = 1; pb = 1; vcap = 1; end
    irq_at("R8 disabled sources", 0); irq_at("R8 disabled sources later", 0);
    @(negedge clk) begin idle = 0; pa = 0; pb = 0; vcap = 0; end

    @(negedge clk) qlow = 1;
    irq_at("R9 irq on queue low", 1);
    repeat (3) @(posedge clk);
    #2 chk("R9 irq level held", {31'b0, host_irq}, 32'h1);
    rd(ADR_A, 4'hF, d);  chk("R9 pending bit", d, 32'h4000_0000);
    wr(ADR_A, 4'hF, 32'h0);
    rd(ADR_A, 4'hF, d);  chk("R10 write zero keeps", d, 32'h4000_0000);
    wr(ADR_A, 4'hF, 32'h4000_0000);
    rd(ADR_A, 4'hF, d);  chk("R10 write one clears", d, 32'h0);
    chk("R10 irq dropped", {31'b0, host_irq}, 32'h0);

    @(negedge clk) qlow = 0;
    @(negedge clk);
    reg_addr = ADR_A; reg_be = 4'hF; reg_wdata = 32'h4000_0000; reg_wr = 1; qlow = 1;
    @(negedge clk) begin reg_wr = 0; reg_be = 0; end
    rd(ADR_A, 4'hF, d);  chk("R11 set wins", d, 32'h4000_0000);
    wr(ADR_A, 4'hF, 32'h4000_0000);
    rd(ADR_A, 4'hF, d);  chk("R10 final clear", d, 32'h0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule